// File: doc/BRIEF.md
# Binary/BCD Calendar Time Counter

This block keeps wall-clock time and the calendar. It holds seven bytes: seconds, minutes, hours, day of week, date of month, month and two-digit year. On each one-cycle `secTick` it moves the stored time forward by one second. Carries ripple through the fields in the same cycle, taking month lengths and leap years into account. One step is called an advance.

The bytes are encoded in one of two ways, chosen by `useBcd`:
- pure binary; or
- packed BCD (tens digit in the upper nibble, units in the lower).

`hour12` chooses between a 0–23 hour and a 12-hour clock. In 12-hour mode bit 7 of the hour byte is the PM flag.

Software loads a byte through the write port and reads any byte through a combinational read port. Holding `setHold` high freezes advancing while software loads a consistent time. A one-cycle `updDone` pulse marks every completed advance.

Top module: `cal_counter`

## Requirements
- R1: Byte indices are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Seconds and minutes count 0..59. Seconds wrap from 59 to 0 and carry into minutes; minutes wrap from 59 to 0 and carry into hours.
- R2: In 24-hour mode (`hour12`=0) hours count 0..23. Going from 23 to 0 starts a new day.
- R3: In 12-hour mode (`hour12`=1):
  - hour byte bits 6:0 hold 1..12 and bit 7 is 1 for PM;
  - the sequence is 12, 1, ..., 11;
  - PM toggles on the step from 11 to 12;
  - the step from 11 PM to 12 AM starts a new day.
- R4: Day of week counts 1..7 and wraps from 7 to 1 on a new day.
- R5: On a new day the date wraps to 1 after the last day of the month:
  - 30 for months 4, 6, 9 and 11;
  - 29 for month 2 when year mod 4 is 0, otherwise 28;
  - 31 for all other months.
- R6: Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R7: With `useBcd`=1 every byte is read and advanced as packed BCD (e.g. 0x09 becomes 0x10). With `useBcd`=0 every byte is plain binary (0x09 becomes 0x0A).
- R8: While `setHold`=1 a tick leaves all bytes unchanged and produces no `updDone`.
- R9: `updDone` is high for exactly one cycle: the cycle in which the advanced time is first readable, one clock after the accepted tick.
- R10: A write to a byte in the same cycle as an advance stores the written value in that byte. The other bytes still advance, with carries taken from the old values.
- R11: Bit 7 of the seconds byte is read-only and always reads 0.
- R12: After reset the bytes read 00:00:00, day 1, date 1, month 1, year 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per second |
| setHold | input | 1 | Freeze advancing while 1 |
| useBcd | input | 1 | 1 = BCD encoding, 0 = binary |
| hour12 | input | 1 | 1 = 12-hour clock with PM flag |
| wrEn | input | 1 | Write strobe for one byte |
| wrIdx | input | 3 | Index of byte to write |
| wrData | input | 8 | Value to write |
| rdIdx | input | 3 | Index of byte to read |
| rdData | output | 8 | Selected byte (0 for indices 7 and above) |
| updDone | output | 1 | Pulse after each completed advance |

## Verification
A wrong carry or month-length decision is visible on the read port as soon as the advance lands. It shows as a wrong digit in the field above the one that wrapped, in the very next cycle after the tick. The cases that expose such faults are:
- boundary values (59, 23, 11 AM/PM, month ends, February in leap and non-leap years, year 99);
- both encodings.

A broken hold or strobe path shows either as a stray `updDone` or as a changed seconds byte right after a held tick. A lost write priority shows as the incremented value instead of the written one.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int FIELD_NUM = 7;
  localparam int IDX_W     = 3;

  typedef enum logic [IDX_W-1:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DOW = 3'd3,
    F_DATE = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } fieldIdx_t;

  typedef struct packed {
    logic advance;
    logic store;
  } ctrlStrobes_t;

  typedef logic [FIELD_NUM-1:0][BYTE_W-1:0] timeVec_t;

  // decode a stored byte to a binary count
  function automatic logic [6:0] toBin(input logic [7:0] v, input logic bcd);
    logic [7:0] sum;
    sum = {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    return bcd ? sum[6:0] : v[6:0];
  endfunction

  // encode a binary count into the selected format
  function automatic logic [7:0] fromBin(input logic [6:0] b, input logic bcd);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b % 7'd10;
    return bcd ? {tens[3:0], ones[3:0]} : {1'b0, b};
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         secTick,
  input  logic         setHold,
  input  logic         wrEn,
  output ctrlStrobes_t strb,
  output logic         updDone
);
  always_comb begin
    strb.advance = secTick && !setHold;
    strb.store   = wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) updDone <= 1'b0;
    else       updDone <= strb.advance;
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int LEAP_PERIOD = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic               useBcd,
  input  logic               hour12,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [BYTE_W-1:0]  rdData,
  output timeVec_t           timeQ
);
  timeVec_t nextQ;

  logic [6:0] secB, minB, hrB, dowB, dateB, monB, yrB;
  logic [6:0] secN, minN, hrN, dowN, dateN, monN, yrN;
  logic       pmB, pmN;
  logic       secWrap, minWrap, dayCarry, dateWrap, monWrap, isLeap;
  logic [6:0] lastDay;
  logic [7:0] hrEnc;

  always_comb begin
    secB  = toBin(timeQ[F_SEC], useBcd);
    minB  = toBin(timeQ[F_MIN], useBcd);
    hrB   = hour12 ? toBin({1'b0, timeQ[F_HOUR][6:0]}, useBcd)
                   : toBin(timeQ[F_HOUR], useBcd);
    pmB   = hour12 && timeQ[F_HOUR][7];
    dowB  = toBin(timeQ[F_DOW], useBcd);
    dateB = toBin(timeQ[F_DATE], useBcd);
    monB  = toBin(timeQ[F_MON], useBcd);
    yrB   = toBin(timeQ[F_YEAR], useBcd);

    secWrap = secB >= 7'd59;
    secN    = secWrap ? 7'd0 : secB + 7'd1;
    minWrap = secWrap && (minB >= 7'd59);
    minN    = secWrap ? (minB >= 7'd59 ? 7'd0 : minB + 7'd1) : minB;

    hrN      = hrB;
    pmN      = pmB;
    dayCarry = 1'b0;
    if (minWrap) begin
      if (hour12) begin
        if (hrB == 7'd11) begin
          hrN      = 7'd12;
          pmN      = !pmB;
          dayCarry = pmB;
        end else if (hrB >= 7'd12) begin
          hrN = 7'd1;
        end else begin
          hrN = hrB + 7'd1;
        end
      end else if (hrB >= 7'd23) begin
        hrN      = 7'd0;
        dayCarry = 1'b1;
      end else begin
        hrN = hrB + 7'd1;
      end
    end

    isLeap = (int'(yrB) % LEAP_PERIOD) == 0;
    case (monB)
      7'd2:                        lastDay = isLeap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     lastDay = 7'd30;
      default:                     lastDay = 7'd31;
    endcase

    dowN     = dayCarry ? (dowB >= 7'd7 ? 7'd1 : dowB + 7'd1) : dowB;
    dateWrap = dayCarry && (dateB >= lastDay);
    dateN    = dayCarry ? (dateWrap ? 7'd1 : dateB + 7'd1) : dateB;
    monWrap  = dateWrap && (monB >= 7'd12);
    monN     = dateWrap ? (monWrap ? 7'd1 : monB + 7'd1) : monB;
    yrN      = monWrap ? (yrB >= 7'd99 ? 7'd0 : yrB + 7'd1) : yrB;

    hrEnc = fromBin(hrN, useBcd);
    nextQ[F_SEC]  = fromBin(secN, useBcd);
    nextQ[F_MIN]  = fromBin(minN, useBcd);
    nextQ[F_HOUR] = hour12 ? {pmN, hrEnc[6:0]} : hrEnc;
    nextQ[F_DOW]  = fromBin(dowN, useBcd);
    nextQ[F_DATE] = fromBin(dateN, useBcd);
    nextQ[F_MON]  = fromBin(monN, useBcd);
    nextQ[F_YEAR] = fromBin(yrN, useBcd);
  end

  for (genvar k = 0; k < FIELD_NUM; k++) begin : g_field
    localparam logic [BYTE_W-1:0] RST_VAL =
      (k == int'(F_DOW) || k == int'(F_DATE) || k == int'(F_MON)) ? 8'd1 : 8'd0;
    logic [BYTE_W-1:0] wrVal;
    if (k == int'(F_SEC)) begin : g_ro
      assign wrVal = {1'b0, wrData[6:0]};
    end else begin : g_rw
      assign wrVal = wrData;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                                   timeQ[k] <= RST_VAL;
      else if (strb.store && wrIdx == IDX_W'(k))   timeQ[k] <= wrVal;
      else if (strb.advance)                       timeQ[k] <= nextQ[k];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELD_NUM; i++)
      if (rdIdx == IDX_W'(i)) rdData = timeQ[i];
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int LEAP_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              setHold,
  input  logic              useBcd,
  input  logic              hour12,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [BYTE_W-1:0] rdData,
  output logic              updDone
);
  ctrlStrobes_t strb;
  timeVec_t     timeQ;

  cal_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .secTick(secTick), .setHold(setHold),
    .wrEn(wrEn), .strb(strb), .updDone(updDone)
  );

  cal_datapath #(.LEAP_PERIOD(LEAP_PERIOD)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .useBcd(useBcd), .hour12(hour12),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .timeQ(timeQ)
  );
endmodule

// File: rtl/cal_counter_checker.sv
module cal_counter_checker
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              setHold,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [BYTE_W-1:0] wrData,
  input logic              updDone,
  input timeVec_t          timeQ
);
  // R9: a strobe only follows an accepted tick
  p_strobe_after_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> $past(secTick && !setHold));

  // R8: a held tick gives no strobe
  p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    setHold |=> !updDone);

  // R8: without an accepted tick or a write nothing moves
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((!secTick || setHold) && !wrEn) |=> $stable(timeQ));

  // R10: a written non-seconds byte holds the written value
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != 3'd0 && wrIdx < 3'd7) |=> timeQ[$past(wrIdx)] == $past(wrData));

  // R11: seconds top bit stays clear
  p_sec_msb_r11: assert property (@(posedge clk) disable iff (!rstN)
    timeQ[0][7] == 1'b0);
endmodule

bind cal_counter cal_counter_checker chkI (.*);

// File: tb/cal_counter_tb_top.sv
`timescale 1ns/100ps
module cal_counter_tb_top;
  typedef logic [6:0][7:0] tvec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0, setHold = 1'b0, useBcd = 1'b0, hour12 = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = '0, rdIdx = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic updDone;

  int nChecks = 0, nFails = 0, strayStrobes = 0;
  tvec_t expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  cal_counter dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .setHold(setHold),
    .useBcd(useBcd), .hour12(hour12), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData), .updDone(updDone)
  );

  function automatic tvec_t mk(logic [7:0] s, logic [7:0] m, logic [7:0] h,
      logic [7:0] dw, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    return {yr, mo, dt, dw, h, m, s};
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrByte(int idx, logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'(idx); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadAll(tvec_t v);
    for (int k = 0; k < 7; k++) wrByte(k, v[k]);
  endtask

  task automatic tickExpect(tvec_t exp, string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic readCheck(int idx, logic [7:0] exp, string tag);
    @(negedge clk);
    rdIdx = 3'(idx);
    #1;
    chk(rdData === exp, tag, rdData, exp);
  endtask

  // monitor: pops expected vectors as advances complete
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && updDone === 1'b1) begin
        if (expQ.size() == 0) begin
          strayStrobes++;
        end else begin
          tvec_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          for (int k = 0; k < 7; k++) begin
            rdIdx = 3'(k);
            #0.4;
            chk(rdData === e[k], t, rdData, e[k]);
          end
          @(negedge clk);
          chk(updDone === 1'b0, "R9 strobe width", {7'd0, updDone}, 8'd0);
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset values
    readCheck(0, 8'h00, "R12 reset sec");
    readCheck(2, 8'h00, "R12 reset hour");
    readCheck(3, 8'h01, "R12 reset dow");
    readCheck(4, 8'h01, "R12 reset date");
    readCheck(5, 8'h01, "R12 reset month");
    readCheck(6, 8'h00, "R12 reset year");

    // binary 24h: full rollover, R1 R2 R4 R6
    loadAll(mk(8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd12, 8'd99));
    tickExpect(mk(0, 0, 0, 1, 1, 1, 0), "R1 R2 R4 R6 binary year rollover");

    // R7 binary vs BCD digit carry
    loadAll(mk(8'h09, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05));
    tickExpect(mk(8'h0A, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05), "R7 binary step");
    useBcd = 1'b1;
    loadAll(mk(8'h09, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05));
    tickExpect(mk(8'h10, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05), "R7 BCD step");

    // R1 minute carry without hour
    loadAll(mk(8'h59, 8'h30, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05));
    tickExpect(mk(8'h00, 8'h31, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05), "R1 minute carry");

    // R5 February, non-leap and leap; 30-day month
    loadAll(mk(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23));
    tickExpect(mk(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23), "R5 Feb 28 non-leap");
    loadAll(mk(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24));
    tickExpect(mk(8'h00, 8'h00, 8'h00, 8'h06, 8'h29, 8'h02, 8'h24), "R5 Feb 29 leap");
    loadAll(mk(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24));
    tickExpect(mk(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h24), "R5 April end");

    // R3 12-hour BCD
    hour12 = 1'b1;
    loadAll(mk(8'h59, 8'h59, 8'h11, 8'h02, 8'h15, 8'h06, 8'h30));
    tickExpect(mk(8'h00, 8'h00, 8'h92, 8'h02, 8'h15, 8'h06, 8'h30), "R3 11AM to 12PM");
    loadAll(mk(8'h59, 8'h59, 8'h92, 8'h02, 8'h15, 8'h06, 8'h30));
    tickExpect(mk(8'h00, 8'h00, 8'h81, 8'h02, 8'h15, 8'h06, 8'h30), "R3 12PM to 1PM");
    loadAll(mk(8'h59, 8'h59, 8'h91, 8'h02, 8'h15, 8'h06, 8'h30));
    tickExpect(mk(8'h00, 8'h00, 8'h12, 8'h03, 8'h16, 8'h06, 8'h30), "R3 11PM to 12AM new day");
    useBcd = 1'b0;
    loadAll(mk(8'd59, 8'd59, 8'h0B, 8'd2, 8'd15, 8'd6, 8'd30));
    tickExpect(mk(8'd0, 8'd0, 8'h8C, 8'd2, 8'd15, 8'd6, 8'd30), "R3 binary 11AM to 12PM");

    // R8 hold
    hour12 = 1'b0; useBcd = 1'b1;
    loadAll(mk(8'h20, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05));
    setHold = 1'b1;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (2) @(negedge clk);
    readCheck(0, 8'h20, "R8 seconds frozen under hold");
    chk(strayStrobes == 0, "R8 no strobe under hold", 8'(strayStrobes), 8'd0);
    setHold = 1'b0;
    tickExpect(mk(8'h21, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05), "R8 resumes after hold");

    // R10 write wins over advance
    expQ.push_back(mk(8'h42, 8'h05, 8'h10, 8'h02, 8'h03, 8'h04, 8'h05));
    tagQ.push_back("R10 write beats advance");
    @(negedge clk);
    secTick = 1'b1; wrEn = 1'b1; wrIdx = 3'd0; wrData = 8'h42;
    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);

    // R11 seconds msb read-only
    wrByte(0, 8'hC5);
    readCheck(0, 8'h45, "R11 seconds bit7 reads 0");
    readCheck(7, 8'h00, "R1 unused index reads 0");

    chk(expQ.size() == 0, "R9 every advance strobed", 8'(expQ.size()), 8'd0);
    chk(strayStrobes == 0, "R9 no stray strobes", 8'(strayStrobes), 8'd0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule